// File: doc/BRIEF.md
# Masked Vectored Interrupt Controller

This block collects 32 level-sensitive request lines and turns them into a single interrupt request for a processor core, together with a vector that identifies the source. Software controls which lines take part through a mask register. When exactly one unmasked line is active, the vector names that line. When several are active at once, the block gives a fixed shared vector. Software then reads the masked-pending register and chooses which one to serve. The block does no priority encoding of its own.

One line is set aside as a non-maskable source. It never reaches the maskable path. It drives its own status register and a dedicated non-maskable output. All state can be read over a simple word-addressed register bus, and only the mask register accepts writes.

Top module: `masked_vic`

## Requirements
- R1: After reset, every register reads 0 and `cpu_irq`, `cpu_vec` and `cpu_nmi` are all 0.
- R2: Raw pending bit i copies `irq_lines[i]` at each clock edge and clears when the line drops. Bit 30, the non-maskable line, always reads 0 in raw pending.
- R3: The masked-pending register always reads raw pending AND mask.
- R4: With no masked-pending bit set, `cpu_irq` is 0 and `cpu_vec` is 0x00.
- R5: With exactly one masked-pending bit i set, where i is in 0..30, `cpu_irq` is 1 and `cpu_vec` is 0x31 + i.
- R6: With two or more masked-pending bits set, `cpu_irq` is 1 and `cpu_vec` is 0x30.
- R7: With only bit 31 set in masked pending, `cpu_irq` is 1 and `cpu_vec` is 0x00, because the vector scan covers bits 0..30 only.
- R8: A write with word index 0 (`bus_addr[4:2]` == 0) loads the mask. Writes to any other word index leave every register unchanged.
- R9: `bus_rdata` returns the word selected by `bus_addr[4:2]`, and the two low address bits are ignored. The words are: 0 mask, 1 raw pending, 2 masked pending, 3 non-maskable status, and 4..7 read 0.
- R10: Non-maskable status bit 30 follows `irq_lines[30]`, and `cpu_nmi` is 1 exactly when that register is non-zero. Line 30 never affects `cpu_irq` or `cpu_vec`, even when mask bit 30 is set.
- R11: `cpu_irq`, `cpu_vec` and `cpu_nmi` are registered. They reflect a line change or a mask write at the first clock edge that samples it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_lines | input | 32 | Level-sensitive request lines; bit 30 is non-maskable |
| bus_addr | input | 5 | Byte address of the register bus |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed word |
| cpu_irq | output | 1 | Maskable interrupt request to the core |
| cpu_vec | output | 8 | Interrupt vector |
| cpu_nmi | output | 1 | Non-maskable interrupt request |

## Verification
The faults that matter here are a mask register that holds the wrong value, or a raw-pending register that lags or sticks. Each one shows up at the ports on the first clock edge after the stimulus. It appears as a wrong vector, a request that does not match the masked-pending readback, or a mask word that a stray write has changed. The bench compares every output sample against a scoreboard after each edge, and reads the registers back after writes to the mask and to the other words. A miscount in the shared-vector logic shows up when two sources collide or when bit 31 is the only one set.

// File: rtl/masked_vic.sv
module masked_vic #(
  parameter int NUM_SRC = 32,
  parameter int NMI_BIT = 30,
  parameter int ADDR_W  = 5,
  parameter int VEC_W   = 8,
  parameter logic [VEC_W-1:0] SHARED_VEC = 8'h30,
  parameter logic [VEC_W-1:0] VEC_BASE   = 8'h31
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] irq_lines,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_wr,
  input  logic [NUM_SRC-1:0] bus_wdata,
  output logic [NUM_SRC-1:0] bus_rdata,
  output logic               cpu_irq,
  output logic [VEC_W-1:0]   cpu_vec,
  output logic               cpu_nmi
);
  localparam int WIDX_W = ADDR_W - 2;
  localparam logic [WIDX_W-1:0] W_MASK = WIDX_W'(0);
  localparam logic [WIDX_W-1:0] W_RAW  = WIDX_W'(1);
  localparam logic [WIDX_W-1:0] W_HIT  = WIDX_W'(2);
  localparam logic [WIDX_W-1:0] W_NMI  = WIDX_W'(3);
  localparam logic [NUM_SRC-1:0] NMI_SEL = NUM_SRC'(1) << NMI_BIT;

  logic [NUM_SRC-1:0] mask_q, raw_q, nmi_q;
  logic [WIDX_W-1:0]  widx;
  logic               mask_wr;
  logic [NUM_SRC-1:0] mask_nx, raw_nx, hit_nx, nmi_nx;
  logic [VEC_W-1:0]   vec_nx;
  int                 hits, idx;
  logic               found;

  assign widx    = bus_addr[ADDR_W-1:2];
  assign mask_wr = bus_wr && (widx == W_MASK);
  assign mask_nx = mask_wr ? bus_wdata : mask_q;
  assign raw_nx  = irq_lines & ~NMI_SEL;
  assign nmi_nx  = irq_lines & NMI_SEL;
  assign hit_nx  = raw_nx & mask_nx;

  always_comb begin
    hits  = 0;
    idx   = 0;
    found = 1'b0;
    for (int i = 0; i < NUM_SRC; i++)
      if (hit_nx[i]) hits++;
    for (int i = 0; i < NUM_SRC - 1; i++)
      if (hit_nx[i]) begin
        found = 1'b1;
        idx   = i;
      end
    if (hits > 1)   vec_nx = SHARED_VEC;
    else if (found) vec_nx = VEC_BASE + VEC_W'(idx);
    else            vec_nx = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q  <= '0;
      raw_q   <= '0;
      nmi_q   <= '0;
      cpu_irq <= 1'b0;
      cpu_vec <= '0;
      cpu_nmi <= 1'b0;
    end else begin
      mask_q  <= mask_nx;
      raw_q   <= raw_nx;
      nmi_q   <= nmi_nx;
      cpu_irq <= |hit_nx;
      cpu_vec <= vec_nx;
      cpu_nmi <= |nmi_nx;
    end
  end

  always_comb begin
    case (widx)
      W_MASK:  bus_rdata = mask_q;
      W_RAW:   bus_rdata = raw_q;
      W_HIT:   bus_rdata = raw_q & mask_q;
      W_NMI:   bus_rdata = nmi_q;
      default: bus_rdata = '0;
    endcase
  end

  assert_irq_tracks_hits_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_irq == ((raw_q & mask_q) != '0));
  assert_idle_vec_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_irq |-> (cpu_vec == '0));
  assert_shared_vec_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(raw_q & mask_q) > 1) |-> (cpu_vec == SHARED_VEC));
  assert_ro_words_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && widx != W_MASK) |=> $stable(mask_q));
  assert_nmi_out_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_nmi == (nmi_q != '0));
  assert_nmi_excluded_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !raw_q[NMI_BIT]);
  assert_raw_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n && $past(rst_n) |-> raw_q == ($past(irq_lines) & ~NMI_SEL));
endmodule

// File: tb/masked_vic_tb.sv
module masked_vic_tb;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] irq_lines = '0;
  logic [4:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        cpu_irq;
  logic [7:0]  cpu_vec;
  logic        cpu_nmi;

  int checks = 0;
  int fails  = 0;
  logic [31:0] mask_m = '0;

  typedef struct {
    logic       irq;
    logic [7:0] vec;
    logic       nmi;
    string      tag;
  } item_t;
  item_t sb[$];

  masked_vic u_dut (
    .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cpu_irq(cpu_irq), .cpu_vec(cpu_vec), .cpu_nmi(cpu_nmi));

  always #(PERIOD/2) clk = ~clk;

  function automatic logic [7:0] model_vec(input logic [31:0] m);
    int n = 0;
    int pos = 0;
    for (int i = 0; i < 32; i++) if (m[i]) begin n++; pos = i; end
    if (n == 0) return 8'h00;
    if (n > 1) return 8'h30;
    if (pos == 31) return 8'h00;
    return 8'h31 + 8'(pos);
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [31:0] lines, input logic wr, input logic [4:0] addr,
                      input logic [31:0] data, input string tag);
    item_t it;
    logic [31:0] raw;
    @(negedge clk);
    irq_lines = lines; bus_wr = wr; bus_addr = addr; bus_wdata = data;
    if (wr && addr[4:2] == 3'd0) mask_m = data;
    raw = lines & ~(32'h1 << 30);
    it.irq = ((raw & mask_m) != 0);
    it.vec = model_vec(raw & mask_m);
    it.nmi = lines[30];
    it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic rd(input logic [4:0] addr, input logic [31:0] exp, input string tag);
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = addr;
    #1 check(tag, bus_rdata, exp);
  endtask

  always begin
    @(posedge clk);
    #1;
    if (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      check({it.tag, " irq"}, {31'b0, cpu_irq}, {31'b0, it.irq});
      check({it.tag, " vec"}, {24'b0, cpu_vec}, {24'b0, it.vec});
      check({it.tag, " nmi"}, {31'b0, cpu_nmi}, {31'b0, it.nmi});
    end
  end

  task automatic finish_run;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(PERIOD * 100000);
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    irq_lines = 32'hFFFF_FFFF;
    repeat (3) @(posedge clk);
    @(negedge clk);
    irq_lines = '0;
    #1;
    check("R1 irq", {31'b0, cpu_irq}, 32'h0);
    check("R1 vec", {24'b0, cpu_vec}, 32'h0);
    check("R1 nmi", {31'b0, cpu_nmi}, 32'h0);
    check("R1 mask", bus_rdata, 32'h0);
    rst_n = 1'b1;
    rd(5'h04, 32'h0, "R1 raw");
    rd(5'h0C, 32'h0, "R1 nmi word");

    step(32'h0000_0020, 1'b0, 5'h00, 32'h0, "R4 unmasked line");
    rd(5'h04, 32'h0000_0020, "R2 raw follows");
    rd(5'h08, 32'h0, "R3 masked view empty");
    step(32'h0000_0020, 1'b1, 5'h00, 32'hFFFF_FFFF, "R11 mask write same edge");
    rd(5'h01, 32'hFFFF_FFFF, "R9 low addr bits ignored");
    step(32'h0000_0001, 1'b0, 5'h00, 32'h0, "R5 bit 0");
    step(32'h2000_0000, 1'b0, 5'h00, 32'h0, "R5 bit 29");
    step(32'h0000_0000, 1'b0, 5'h00, 32'h0, "R2 line drops");
    rd(5'h04, 32'h0, "R2 raw clears");
    step(32'h0000_0104, 1'b0, 5'h00, 32'h0, "R6 two sources");
    step(32'h8000_0001, 1'b0, 5'h00, 32'h0, "R6 bits 0 and 31");
    step(32'h8000_0000, 1'b0, 5'h00, 32'h0, "R7 bit 31 alone");
    step(32'h4000_0000, 1'b0, 5'h00, 32'h0, "R10 nmi only");
    rd(5'h0C, 32'h4000_0000, "R10 nmi status");
    rd(5'h04, 32'h0, "R10 raw excludes nmi");
    rd(5'h08, 32'h0, "R10 masked excludes nmi");
    step(32'h4000_0010, 1'b0, 5'h00, 32'h0, "R10 nmi with bit 4");
    step(32'h0000_0F00, 1'b1, 5'h00, 32'h0000_0300, "R3 partial mask");
    rd(5'h08, 32'h0000_0300, "R3 masked view");
    step(32'h0000_0F00, 1'b1, 5'h00, 32'h0000_0200, "R5 mask narrows to bit 9");
    step(32'h0000_0F00, 1'b1, 5'h04, 32'hFFFF_FFFF, "R8 write word 1");
    step(32'h0000_0F00, 1'b1, 5'h08, 32'hFFFF_FFFF, "R8 write word 2");
    step(32'h0000_0F00, 1'b1, 5'h0C, 32'hFFFF_FFFF, "R8 write word 3");
    rd(5'h00, 32'h0000_0200, "R8 mask unchanged");
    rd(5'h04, 32'h0000_0F00, "R8 raw unchanged");
    rd(5'h0C, 32'h0, "R8 nmi word unchanged");
    rd(5'h10, 32'h0, "R9 word 4 reads zero");
    rd(5'h1C, 32'h0, "R9 word 7 reads zero");
    step(32'h0000_0F00, 1'b1, 5'h00, 32'h0, "R4 mask cleared");
    step(32'h0000_0000, 1'b0, 5'h00, 32'h0, "R4 idle");
    @(negedge clk);
    @(negedge clk);
    finish_run();
  end
endmodule